// File: doc/BRIEF.md
# Programmable chip-select wait-state generator

This block sits between a bus master and a set of memory banks. For each access it compares the address with eight programmable bank windows. It picks one bank and holds that bank's select line for the whole access. It then ends the access with a one-clock internal transfer-acknowledge pulse. SRAM-type banks drive a chip-select line and DRAM-type banks drive a row-strobe line.

Each bank is programmed through a single-cycle configuration write. The fields are a valid flag, a base address, a mask, a memory type (SRAM or DRAM), a 4-bit cycle-length code, a page-mode enable and an external-acknowledge select. The access length depends on these inputs:
- the code;
- the memory type;
- whether the master is internal or external;
- whether the access hits the open DRAM page.

For a bank set to use an external acknowledge, the code is not used. The access then ends one clock after the external acknowledge input is seen.

Top module: `cs_wait_gen`

## Requirements
- R1: An internal-master access to an SRAM bank asserts the internal acknowledge in clock code+2, counting the first clock after the accepting edge as clock 1. Code 0 gives 2 clocks and code 15 gives 17 clocks.
- R2: An access to a DRAM bank lasts code+3 clocks when the page short cycle does not apply. Code 0 gives 3 clocks.
- R3: A DRAM access lasts code+2 clocks only when all three of these hold: the bank's page-mode enable is 1, acc_ext_master is 0, and acc_page_hit is 1. Code 0 then gives 2 clocks.
- R4: When acc_ext_master is 1, an access lasts at least 3 clocks. Apart from that, the same per-bank code rules apply as for an internal master.
- R5: For a bank with its external-acknowledge select set, the code has no effect. The internal acknowledge pulses in the clock after the first clock edge that samples ext_ack_i high while the access is active.
- R6: When several banks match, only the lowest-numbered bank's line asserts.
- R7: Bank i matches when its valid flag is 1 and (acc_addr AND mask) equals (base AND mask). Address bits outside the mask are ignored.
- R8: An access that matches no bank asserts no select line and no acknowledge.
- R9: The selected line is cs_o[i] for an SRAM bank (memory type 0) and ras_o[i] for a DRAM bank (memory type 1). It is asserted from clock 1 up to and including the acknowledge clock, and it drops in the next clock. ta_o is high for exactly one clock.
- R10: acc_start is ignored while an access is active. A start held high through an access does not restart it or lengthen it.
- R11: A synchronous active-low reset clears every bank and the sequencer. After reset no line or acknowledge is asserted, and a previously matching address selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Bank configuration write strobe |
| cfg_idx | input | IDX_W | Bank number written |
| cfg_valid | input | 1 | Bank enable |
| cfg_dram | input | 1 | Memory type: 1 = DRAM, 0 = SRAM |
| cfg_page_en | input | 1 | Page-mode enable |
| cfg_ext_ack | input | 1 | Use external acknowledge |
| cfg_code | input | CODE_W | Cycle-length code |
| cfg_base | input | ADDR_W | Bank base address |
| cfg_mask | input | ADDR_W | Bank address mask |
| acc_start | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access address |
| acc_ext_master | input | 1 | Access comes from an external master |
| acc_page_hit | input | 1 | Access hits the open DRAM page |
| ext_ack_i | input | 1 | External acknowledge |
| cs_o | output | NUM_BANKS | SRAM chip selects, active high |
| ras_o | output | NUM_BANKS | DRAM row strobes, active high |
| ta_o | output | 1 | Internal transfer-acknowledge pulse |

## Verification
The bench builds the block with its default parameters: eight banks, a 32-bit address and a 4-bit code. With these values the code reaches its full range, which brings the 17-clock SRAM and 2-clock page-hit DRAM extremes within reach. Eight banks let two windows overlap with banks 1 and 4, so the priority order can be seen and then shifted by invalidating bank 1. The behavioural model recomputes the expected bank and length for every access and compares both select vectors and the acknowledge on every clock.

// File: rtl/cswg_pkg.sv
package cswg_pkg;
    localparam int ADDR_W = 32;
    localparam int CODE_W = 4;
    localparam int LEN_W  = $clog2((1 << CODE_W) + 3);

    typedef struct packed {
        logic              valid;
        logic              dram;
        logic              page_en;
        logic              ext_ack;
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } bank_cfg_t;

    // Clocks for one counted access, 2..code_max+3
    function automatic logic [LEN_W-1:0] cyc_len(bank_cfg_t b, logic ext_m, logic pg_hit);
        logic [LEN_W-1:0] n;
        n = LEN_W'(b.code) + LEN_W'(2);
        if (b.dram && !(b.page_en && !ext_m && pg_hit))
            n = n + LEN_W'(1);
        if (ext_m && n < LEN_W'(3))
            n = LEN_W'(3);
        return n;
    endfunction
endpackage

// File: rtl/cswg_bank_regs.sv
module cswg_bank_regs
    import cswg_pkg::*;
#(
    parameter int NB    = 8,
    parameter int IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  bank_cfg_t            wdata,
    output bank_cfg_t [NB-1:0]   banks_o
);
    bank_cfg_t [NB-1:0] banks_d, banks_q;

    always_comb begin
        banks_d = banks_q;
        for (int i = 0; i < NB; i++) begin
            if (we && int'(idx) == i)
                banks_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) banks_q <= '0;
        else        banks_q <= banks_d;
    end

    assign banks_o = banks_q;
endmodule

// File: rtl/cswg_decode.sv
module cswg_decode
    import cswg_pkg::*;
#(
    parameter int NB    = 8,
    parameter int IDX_W = 3
) (
    input  bank_cfg_t [NB-1:0]   banks_i,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 ext_m,
    input  logic                 pg_hit,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [LEN_W-1:0]     len_o,
    output logic                 use_ext_o,
    output logic                 dram_o
);
    logic [NB-1:0] match;
    bank_cfg_t     win;

    for (genvar g = 0; g < NB; g++) begin : g_match
        assign match[g] = banks_i[g].valid &&
                          ((addr & banks_i[g].mask) == (banks_i[g].base & banks_i[g].mask));
    end

    // Lowest index wins: scan downward so the last write is the lowest match
    always_comb begin
        idx_o = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    always_comb begin
        win = '0;
        for (int i = 0; i < NB; i++) begin
            if (int'(idx_o) == i) win = banks_i[i];
        end
    end

    assign hit_o     = |match;
    assign len_o     = cyc_len(win, ext_m, pg_hit);
    assign use_ext_o = win.ext_ack;
    assign dram_o    = win.dram;
endmodule

// File: rtl/cswg_seq.sv
module cswg_seq
    import cswg_pkg::*;
#(
    parameter int NB    = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LEN_W-1:0]  len,
    input  logic              use_ext,
    input  logic              dram,
    input  logic              ext_ack,
    output logic [NB-1:0]     cs_o,
    output logic [NB-1:0]     ras_o,
    output logic              ta_o
);
    typedef struct packed {
        logic             active;
        logic             ta;
        logic [LEN_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             dram;
        logic             use_ext;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ta = 1'b0;
        if (!st_q.active) begin
            if (start && hit) begin
                st_d.active  = 1'b1;
                st_d.cnt     = len - LEN_W'(1);
                st_d.idx     = idx;
                st_d.dram    = dram;
                st_d.use_ext = use_ext;
            end
        end else if (st_q.ta) begin
            st_d.active = 1'b0;
        end else if (st_q.use_ext) begin
            st_d.ta = ext_ack;
        end else begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
            st_d.ta  = (st_q.cnt == LEN_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NB; g++) begin : g_line
        logic mine;
        assign mine     = st_q.active && (int'(st_q.idx) == g);
        assign cs_o[g]  = mine && !st_q.dram;
        assign ras_o[g] = mine &&  st_q.dram;
    end

    assign ta_o = st_q.ta;
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
    import cswg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic                  cfg_valid,
    input  logic                  cfg_dram,
    input  logic                  cfg_page_en,
    input  logic                  cfg_ext_ack,
    input  logic [CODE_W-1:0]     cfg_code,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [ADDR_W-1:0]     cfg_mask,
    input  logic                  acc_start,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_ext_master,
    input  logic                  acc_page_hit,
    input  logic                  ext_ack_i,
    output logic [NUM_BANKS-1:0]  cs_o,
    output logic [NUM_BANKS-1:0]  ras_o,
    output logic                  ta_o
);
    bank_cfg_t                 wdata;
    bank_cfg_t [NUM_BANKS-1:0] banks;
    logic                      hit, use_ext, dram;
    logic [IDX_W-1:0]          idx;
    logic [LEN_W-1:0]          len;

    always_comb begin
        wdata.valid   = cfg_valid;
        wdata.dram    = cfg_dram;
        wdata.page_en = cfg_page_en;
        wdata.ext_ack = cfg_ext_ack;
        wdata.code    = cfg_code;
        wdata.base    = cfg_base;
        wdata.mask    = cfg_mask;
    end

    cswg_bank_regs #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .wdata(wdata), .banks_o(banks)
    );

    cswg_decode #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_dec (
        .banks_i(banks), .addr(acc_addr), .ext_m(acc_ext_master),
        .pg_hit(acc_page_hit), .hit_o(hit), .idx_o(idx), .len_o(len),
        .use_ext_o(use_ext), .dram_o(dram)
    );

    cswg_seq #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(acc_start), .hit(hit), .idx(idx),
        .len(len), .use_ext(use_ext), .dram(dram), .ext_ack(ext_ack_i),
        .cs_o(cs_o), .ras_o(ras_o), .ta_o(ta_o)
    );
endmodule

// File: rtl/cswg_chk.sv
module cswg_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB-1:0] cs_o,
    input logic [NB-1:0] ras_o,
    input logic          ta_o
);
    logic [2*NB-1:0] sel;
    assign sel = {ras_o, cs_o};

    // R6: at most one line of either kind
    p_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R9: acknowledge lasts one clock
    p_ta_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |=> !ta_o);

    // R8: no acknowledge without a selected line
    p_ta_has_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |-> (sel != '0));

    // R10: the selected line holds until the acknowledge
    p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != '0) && !ta_o) |=> $stable(sel));

    // R9: the line drops right after the acknowledge
    p_sel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |=> (sel == '0));

    // R1: no access is shorter than two clocks
    p_min_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|sel) |-> !ta_o);
endmodule

bind cs_wait_gen cswg_chk #(.NB(NUM_BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_o(cs_o), .ras_o(ras_o), .ta_o(ta_o)
);

// File: tb/cs_wait_gen_tb.sv
module cs_wait_gen_tb;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_valid, cfg_dram, cfg_page_en, cfg_ext_ack;
    logic [2:0]  cfg_idx;
    logic [3:0]  cfg_code;
    logic [31:0] cfg_base, cfg_mask;
    logic        acc_start, acc_ext_master, acc_page_hit, ext_ack_i;
    logic [31:0] acc_addr;
    logic [NB-1:0] cs_o, ras_o;
    logic        ta_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural bank model
    bit          m_valid [NB];
    bit          m_dram  [NB];
    bit          m_pg    [NB];
    bit          m_ext   [NB];
    int          m_code  [NB];
    logic [31:0] m_base  [NB];
    logic [31:0] m_mask  [NB];

    always #10 clk = ~clk;

    cs_wait_gen #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_dram(cfg_dram), .cfg_page_en(cfg_page_en),
        .cfg_ext_ack(cfg_ext_ack), .cfg_code(cfg_code), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .acc_start(acc_start), .acc_addr(acc_addr),
        .acc_ext_master(acc_ext_master), .acc_page_hit(acc_page_hit),
        .ext_ack_i(ext_ack_i), .cs_o(cs_o), .ras_o(ras_o), .ta_o(ta_o)
    );

    task automatic chk(string req, logic [NB-1:0] cs_e, logic [NB-1:0] ras_e, logic ta_e);
        checks++;
        if (cs_o !== cs_e || ras_o !== ras_e || ta_o !== ta_e) begin
            errors++;
            $display("FAIL %s: cs=%h ras=%h ta=%b expected cs=%h ras=%h ta=%b",
                     req, cs_o, ras_o, ta_o, cs_e, ras_e, ta_e);
        end
    endtask

    task automatic set_bank(int b, bit v, bit dr, bit pg, bit ex, int code,
                            logic [31:0] base, logic [31:0] mask);
        cfg_we = 1'b1; cfg_idx = 3'(b); cfg_valid = v; cfg_dram = dr;
        cfg_page_en = pg; cfg_ext_ack = ex; cfg_code = 4'(code);
        cfg_base = base; cfg_mask = mask;
        m_valid[b] = v; m_dram[b] = dr; m_pg[b] = pg; m_ext[b] = ex;
        m_code[b] = code; m_base[b] = base; m_mask[b] = mask;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Starts at a negedge, ends at a negedge with the block idle
    task automatic access(string req, logic [31:0] addr, bit extm, bit phit,
                          int ackdel, bit hold);
        int b = -1;
        int len;
        logic [NB-1:0] line;
        for (int i = 0; i < NB; i++)
            if (b < 0 && m_valid[i] && ((addr & m_mask[i]) == (m_base[i] & m_mask[i])))
                b = i;
        acc_start = 1'b1; acc_addr = addr; acc_ext_master = extm; acc_page_hit = phit;
        if (b < 0) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                acc_start = 1'b0;
                chk(req, '0, '0, 1'b0);
            end
            return;
        end
        if (m_ext[b]) len = ackdel + 1;
        else begin
            if (m_dram[b] && !(m_pg[b] && !extm && phit)) len = m_code[b] + 3;
            else len = m_code[b] + 2;
            if (extm && len < 3) len = 3;
        end
        line = NB'(1) << b;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (!hold || i == len) acc_start = 1'b0;
            chk(req, m_dram[b] ? '0 : line, m_dram[b] ? line : '0, i == len);
            ext_ack_i = m_ext[b] && (i == ackdel);
        end
        @(negedge clk);
        ext_ack_i = 1'b0;
        chk(req, '0, '0, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_dram = 1'b0;
        cfg_page_en = 1'b0; cfg_ext_ack = 1'b0; cfg_code = '0; cfg_base = '0;
        cfg_mask = '0; acc_start = 1'b0; acc_addr = '0; acc_ext_master = 1'b0;
        acc_page_hit = 1'b0; ext_ack_i = 1'b0;
        for (int i = 0; i < NB; i++) begin
            m_valid[i] = 0; m_dram[i] = 0; m_pg[i] = 0; m_ext[i] = 0;
            m_code[i] = 0; m_base[i] = '0; m_mask[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", '0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        access("R11 no bank after reset", 32'h0000_0000, 0, 0, 0, 0);

        // R1 SRAM internal
        set_bank(0, 1, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_F000);
        access("R1 sram code0", 32'h0000_1000, 0, 0, 0, 0);
        access("R7 mask ignores low bits", 32'h0000_1ABC, 0, 0, 0, 0);
        set_bank(0, 1, 0, 0, 0, 15, 32'h0000_1000, 32'h0000_F000);
        access("R1 sram code15", 32'h0000_1004, 0, 0, 0, 0);
        set_bank(0, 1, 0, 0, 0, 5, 32'h0000_1000, 32'h0000_F000);
        access("R1 sram code5", 32'h0000_1008, 0, 0, 0, 0);

        // R4 external master
        access("R4 ext master code5", 32'h0000_1008, 1, 0, 0, 0);
        set_bank(0, 1, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_F000);
        access("R4 ext master code0 min3", 32'h0000_1000, 1, 0, 0, 0);

        // R2 / R3 DRAM
        set_bank(3, 1, 1, 0, 0, 1, 32'h0000_2000, 32'h0000_F000);
        access("R2 dram code1", 32'h0000_2010, 0, 1, 0, 0);
        set_bank(3, 1, 1, 0, 0, 0, 32'h0000_2000, 32'h0000_F000);
        access("R2 dram code0 page off", 32'h0000_2010, 0, 1, 0, 0);
        set_bank(3, 1, 1, 1, 0, 0, 32'h0000_2000, 32'h0000_F000);
        access("R3 dram page hit", 32'h0000_2010, 0, 1, 0, 0);
        access("R3 dram page miss", 32'h0000_2010, 0, 0, 0, 0);
        access("R3 dram page hit ext master", 32'h0000_2010, 1, 1, 0, 0);
        set_bank(3, 1, 1, 1, 0, 15, 32'h0000_2000, 32'h0000_F000);
        access("R2 dram code15 miss", 32'h0000_2010, 0, 0, 0, 0);

        // R5 external acknowledge
        set_bank(5, 1, 0, 0, 1, 0, 32'h0000_3000, 32'h0000_F000);
        access("R5 ext ack delay4", 32'h0000_3000, 0, 0, 4, 0);
        access("R5 ext ack delay1", 32'h0000_3000, 0, 0, 1, 0);
        set_bank(5, 1, 1, 0, 1, 15, 32'h0000_3000, 32'h0000_F000);
        access("R5 ext ack dram code ignored", 32'h0000_3000, 1, 0, 2, 0);

        // R6 priority, R7 valid
        set_bank(4, 1, 0, 0, 0, 2, 32'h0000_4000, 32'h0000_F000);
        set_bank(1, 1, 1, 0, 0, 1, 32'h0000_4000, 32'h0000_C000);
        access("R6 bank1 over bank4", 32'h0000_4020, 0, 0, 0, 0);
        set_bank(1, 0, 1, 0, 0, 1, 32'h0000_4000, 32'h0000_C000);
        access("R7 invalid bank1 skipped", 32'h0000_4020, 0, 0, 0, 0);

        // R8 no match, R10 held start
        access("R8 no match", 32'h0000_9000, 0, 0, 0, 0);
        access("R10 held start", 32'h0000_4020, 0, 0, 0, 1);

        // R11 reset clears banks
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) m_valid[i] = 0;
        access("R11 banks cleared", 32'h0000_1000, 0, 0, 0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule